// File: doc/BRIEF.md
# Flash Bus-Control Mode Controller

This block models the control side of a byte-wide flash device's bus interface. It samples the active-low chip enable, output enable, write enable and reset/power-down pins on a system clock. It decodes command bytes from the data bus into a read mode: array, identifier or status. From the pins and the internal state it produces a data-bus drive enable, a read-source select, a status byte and a ready/busy flag. The flash array itself, the supply sensing and the real erase and program algorithms sit outside the block. A busy operation is modelled as a cycle counter of programmable length.

Holding the reset pin low for long enough puts the block into deep power-down. This aborts any operation in flight, returns the block to array mode with status 80H, and keeps ready/busy low until wake-up completes. After the pin returns high, reads are held off for a wake-up delay and command writes for a longer recovery delay. A low pulse shorter than the minimum low time changes no state.

Top module: `flash_busctl`

## Requirements
- R1: `dq_oe` is 1 only while `ce_n`=0, `oe_n`=0, `we_n`=1 and `rp_n`=1 and the block is awake. Pulling `we_n` low with the other conditions met drops it to 0.
- R2: With `oe_n`=1, `dq_oe` is 0.
- R3: With `ce_n`=1, `dq_oe` is 0 whatever `oe_n` is. A busy operation keeps running while the chip is deselected, and `ry_by` rises after its full length.
- R4: A command byte is taken on a rising edge of `we_n` while `ce_n`=0. 0xFF selects array (`rd_sel`=0), 0x90 selects identifier (`rd_sel`=1) and 0x70 selects status (`rd_sel`=2). A strobe with `ce_n`=1 is ignored.
- R5: After power-on reset, and on entry to deep power-down, `rd_sel`=0 and `status_q`=0x80.
- R6: `rp_n` held low for at least T_LOW clock edges enters deep power-down. A shorter low pulse leaves the read mode unchanged and causes no wake-up delay.
- R7: After `rp_n` rises out of power-down, `dq_oe` stays 0 until T_WAKE cycles have passed.
- R8: Power-down entered during a busy operation aborts it, and `ry_by` stays 0 until the wake-up delay ends.
- R9: Command writes are ignored until T_REC cycles after `rp_n` rises out of power-down.
- R10: Setup 0x40 followed by any byte, setup 0x20 followed by 0xD0, or setup 0x60 followed by 0xD0 or 0x01 starts an operation. For OP_CYCLES cycles `ry_by`=0, `status_q[7]`=0 and `rd_sel`=2. Any other confirm byte sets `status_q[4]` and starts nothing.
- R11: A valid confirm while `vpp_ok`=0 starts nothing and sets `status_q[3]`. Command 0x50 clears bits 4 and 3.
- R12: `status_q[7]` is 1 when idle and 0 while an operation runs. All other status bits are 0 unless set by R10 or R11.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Power-on reset, active low |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low; commands taken on its rising edge |
| rp_n | input | 1 | Reset/power-down pin, active low |
| dq_in | input | 8 | Command byte from the data bus |
| vpp_ok | input | 1 | Program supply is above its lockout level |
| dq_oe | output | 1 | Drive enable for the data bus |
| rd_sel | output | 2 | Read source: 0 array, 1 identifier, 2 status |
| status_q | output | 8 | Status byte |
| ry_by | output | 1 | 1 when ready, 0 while busy or recovering from an abort |

## Verification
The hardest case to reach is a power-down abort in the middle of an operation. It needs a complete two-step command sequence, a reset pulse longer than T_LOW that starts while the counter is still running, and then a watch across the wake-up window. The bench shortens every delay through parameters. It starts a program operation, drops `rp_n` for a few cycles beyond T_LOW, and samples `ry_by` inside and after the wake-up delay. It probes the recovery window by writing an identifier command before T_REC has passed and again after it.

// File: rtl/flash_busctl.sv
module flash_busctl #(
  parameter int T_LOW     = 16,
  parameter int T_WAKE    = 32,
  parameter int T_REC     = 48,
  parameter int OP_CYCLES = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ce_n,
  input  logic       oe_n,
  input  logic       we_n,
  input  logic       rp_n,
  input  logic [7:0] dq_in,
  input  logic       vpp_ok,
  output logic       dq_oe,
  output logic [1:0] rd_sel,
  output logic [7:0] status_q,
  output logic       ry_by
);
  localparam int REC_MAX = (T_WAKE > T_REC) ? T_WAKE : T_REC;
  localparam int LW = $clog2(T_LOW + 1);
  localparam int RW = $clog2(REC_MAX + 1);
  localparam int BW = $clog2(OP_CYCLES + 1);
  localparam logic [1:0] M_ARRAY = 2'd0, M_IDENT = 2'd1, M_STAT = 2'd2;
  localparam logic [1:0] P_NONE = 2'd0, P_ERASE = 2'd1, P_PROG = 2'd2, P_LOCK = 2'd3;

  logic          we_q, pd_q, busy_q, abort_hold, err_vpp, err_seq;
  logic [1:0]    mode_q, pend_q;
  logic [LW-1:0] low_cnt;
  logic [RW-1:0] rec_cnt;
  logic [BW-1:0] busy_cnt;
  logic          awake, wr_ok, wr_stb, pd_enter, go;

  assign awake    = rec_cnt >= RW'(T_WAKE);
  assign wr_ok    = rec_cnt >= RW'(T_REC);
  assign wr_stb   = we_n & ~we_q & ~ce_n & rp_n & ~pd_q & wr_ok & ~busy_q;
  assign pd_enter = ~rp_n & (low_cnt == LW'(T_LOW - 1));

  always_comb begin
    case (pend_q)
      P_PROG:  go = 1'b1;
      P_ERASE: go = (dq_in == 8'hD0);
      P_LOCK:  go = (dq_in == 8'hD0) || (dq_in == 8'h01);
      default: go = 1'b0;
    endcase
  end

  assign dq_oe    = ~ce_n & ~oe_n & we_n & rp_n & ~pd_q & awake;
  assign rd_sel   = busy_q ? M_STAT : mode_q;
  assign status_q = {~busy_q, 2'b00, err_seq, err_vpp, 3'b000};
  assign ry_by    = ~busy_q & ~abort_hold;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      we_q       <= 1'b1;
      pd_q       <= 1'b0;
      busy_q     <= 1'b0;
      abort_hold <= 1'b0;
      err_vpp    <= 1'b0;
      err_seq    <= 1'b0;
      mode_q     <= M_ARRAY;
      pend_q     <= P_NONE;
      low_cnt    <= '0;
      rec_cnt    <= RW'(REC_MAX);
      busy_cnt   <= '0;
    end else begin
      we_q <= we_n;
      if (rp_n) low_cnt <= '0;
      else if (low_cnt != LW'(T_LOW)) low_cnt <= low_cnt + 1'b1;
      if (pd_q) rec_cnt <= '0;
      else if (rec_cnt != RW'(REC_MAX)) rec_cnt <= rec_cnt + 1'b1;
      if (pd_q && rp_n) pd_q <= 1'b0;
      if (abort_hold && awake && !pd_q) abort_hold <= 1'b0;
      if (busy_q) begin
        if (busy_cnt == BW'(OP_CYCLES - 1)) busy_q <= 1'b0;
        else busy_cnt <= busy_cnt + 1'b1;
      end
      if (wr_stb) begin
        if (pend_q != P_NONE) begin
          pend_q <= P_NONE;
          mode_q <= M_STAT;
          if (!go) err_seq <= 1'b1;
          else if (!vpp_ok) err_vpp <= 1'b1;
          else begin
            busy_q   <= 1'b1;
            busy_cnt <= '0;
          end
        end else begin
          case (dq_in)
            8'hFF: mode_q <= M_ARRAY;
            8'h90: mode_q <= M_IDENT;
            8'h70: mode_q <= M_STAT;
            8'h50: begin err_seq <= 1'b0; err_vpp <= 1'b0; end
            8'h20: begin pend_q <= P_ERASE; mode_q <= M_STAT; end
            8'h40: begin pend_q <= P_PROG;  mode_q <= M_STAT; end
            8'h60: begin pend_q <= P_LOCK;  mode_q <= M_STAT; end
            default: ;
          endcase
        end
      end
      if (pd_enter) begin
        pd_q       <= 1'b1;
        rec_cnt    <= '0;
        mode_q     <= M_ARRAY;
        pend_q     <= P_NONE;
        busy_q     <= 1'b0;
        err_seq    <= 1'b0;
        err_vpp    <= 1'b0;
        abort_hold <= busy_q;
      end
    end
  end

  assert_pd_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
    pd_enter |=> (rd_sel == M_ARRAY && status_q == 8'h80));
  assert_wake_gap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    pd_q |=> !dq_oe);
  assert_abort_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (pd_enter && busy_q) |=> (!ry_by && pd_q));
  assert_rec_block_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_ok && rp_n) |=> ($stable(mode_q) && $stable(pend_q)));
  assert_busy_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q |-> (busy_cnt < BW'(OP_CYCLES)));
  assert_op_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stb && pend_q != P_NONE && go && vpp_ok) |=> (!ry_by && !status_q[7]));
endmodule

// File: tb/flash_busctl_tb_top.sv
module flash_busctl_tb_top;
  localparam int TL = 4, TW = 8, TR = 12, OPC = 20;
  logic clk = 0, rst_n = 0, ce_n = 1, oe_n = 1, we_n = 1, rp_n = 1, vpp_ok = 1;
  logic [7:0] dq_in = 8'h00;
  logic dq_oe, ry_by;
  logic [1:0] rd_sel;
  logic [7:0] status_q;
  int errs = 0, checks = 0;
  bit done = 0;

  always #4 clk = ~clk;

  flash_busctl #(.T_LOW(TL), .T_WAKE(TW), .T_REC(TR), .OP_CYCLES(OPC)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .rp_n(rp_n),
    .dq_in(dq_in), .vpp_ok(vpp_ok), .dq_oe(dq_oe), .rd_sel(rd_sel),
    .status_q(status_q), .ry_by(ry_by));

  // {ce_n, command, expected rd_sel}
  localparam logic [10:0] VEC [8] = '{
    {1'b0, 8'h90, 2'd1}, {1'b0, 8'h70, 2'd2}, {1'b1, 8'hFF, 2'd2}, {1'b0, 8'hFF, 2'd0},
    {1'b0, 8'h70, 2'd2}, {1'b0, 8'h90, 2'd1}, {1'b1, 8'h70, 2'd1}, {1'b0, 8'hFF, 2'd0}};

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic ce, input logic [7:0] d);
    @(negedge clk); ce_n = ce; dq_in = d; we_n = 0;
    @(negedge clk); we_n = 1;
    @(negedge clk); ce_n = 0;
  endtask

  initial begin
    cyc(3); rst_n = 1; cyc(1);
    chk("R5 reset rd_sel", {6'd0, rd_sel}, 8'd0);
    chk("R5 reset status", status_q, 8'h80);
    chk("R12 reset ready", {7'd0, ry_by}, 8'd1);
    chk("R3 deselected", {7'd0, dq_oe}, 8'd0);
    ce_n = 0; cyc(1);
    chk("R2 oe high", {7'd0, dq_oe}, 8'd0);
    oe_n = 0; cyc(1);
    chk("R1 read enabled", {7'd0, dq_oe}, 8'd1);
    we_n = 0; cyc(1);
    chk("R1 we low", {7'd0, dq_oe}, 8'd0);
    we_n = 1; ce_n = 1; cyc(1);
    chk("R3 ce high oe low", {7'd0, dq_oe}, 8'd0);
    oe_n = 1;

    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][10], VEC[i][9:2]);
      chk("R4 command mode", {6'd0, rd_sel}, {6'd0, VEC[i][1:0]});
    end

    // R10 program, completes with chip deselected (R3)
    wr(0, 8'h40); wr(0, 8'h5A);
    chk("R10 busy ry_by", {7'd0, ry_by}, 8'd0);
    chk("R12 busy status", status_q, 8'h00);
    chk("R10 busy rd_sel", {6'd0, rd_sel}, 8'd2);
    ce_n = 1; cyc(OPC);
    chk("R3 op completes deselected", {7'd0, ry_by}, 8'd1);
    chk("R12 idle status", status_q, 8'h80);

    wr(0, 8'h20); wr(0, 8'hD0);
    chk("R10 erase start", {7'd0, ry_by}, 8'd0);
    cyc(OPC);
    wr(0, 8'h60); wr(0, 8'h01);
    chk("R10 lock start", {7'd0, ry_by}, 8'd0);
    cyc(OPC);
    wr(0, 8'h20); wr(0, 8'h55);
    chk("R10 bad confirm status", status_q, 8'h90);
    chk("R10 bad confirm idle", {7'd0, ry_by}, 8'd1);
    wr(0, 8'h50);
    chk("R11 clear", status_q, 8'h80);
    vpp_ok = 0;
    wr(0, 8'h40); wr(0, 8'hAA);
    chk("R11 vpp low status", status_q, 8'h88);
    chk("R11 vpp low idle", {7'd0, ry_by}, 8'd1);
    vpp_ok = 1; wr(0, 8'h50);
    chk("R11 clear again", status_q, 8'h80);

    // R6 short pulse ignored
    wr(0, 8'h90); oe_n = 0;
    @(negedge clk); rp_n = 0; cyc(1);
    chk("R1 rp low", {7'd0, dq_oe}, 8'd0);
    cyc(TL - 3); rp_n = 1; cyc(1);
    chk("R6 short pulse mode", {6'd0, rd_sel}, 8'd1);
    chk("R6 short pulse no wake", {7'd0, dq_oe}, 8'd1);

    // R6/R7/R9 long pulse
    rp_n = 0; cyc(TL + 2);
    chk("R6 long pulse mode", {6'd0, rd_sel}, 8'd0);
    rp_n = 1; cyc(2);
    chk("R7 wake gap", {7'd0, dq_oe}, 8'd0);
    oe_n = 1; wr(0, 8'h90);
    chk("R9 write in recovery ignored", {6'd0, rd_sel}, 8'd0);
    cyc(TR); oe_n = 0; cyc(1);
    chk("R7 awake", {7'd0, dq_oe}, 8'd1);
    oe_n = 1; wr(0, 8'h90);
    chk("R9 write after recovery", {6'd0, rd_sel}, 8'd1);

    // R8 abort
    wr(0, 8'h40); wr(0, 8'h11);
    chk("R8 op running", {7'd0, ry_by}, 8'd0);
    rp_n = 0; cyc(TL + 2);
    chk("R8 abort status", status_q, 8'h80);
    chk("R8 abort rd_sel", {6'd0, rd_sel}, 8'd0);
    chk("R8 held busy in pd", {7'd0, ry_by}, 8'd0);
    rp_n = 1; cyc(3);
    chk("R8 held busy waking", {7'd0, ry_by}, 8'd0);
    cyc(TW + 2);
    chk("R8 ready after wake", {7'd0, ry_by}, 8'd1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end
endmodule